// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for an LCD panel from three packed timing words that software would normally keep in memory-mapped registers. In this block the words are plain input ports. It drives horizontal sync, vertical sync, data-enable, a panel clock, a panel power gate, and the column and row of the pixel being shown. Each line runs through sync, back porch, active pixels and front porch. Each frame runs through sync lines, back-porch lines, active lines and front-porch lines. Scanning is always progressive; there is no interlace.

The fields use mixed encodings. The sync widths, the horizontal porches and the line count hold their value minus one. The active width is held in units of 16 pixels, minus one. The two vertical porches hold raw line counts. In dual-panel mode the line count covers one half of the screen, and the two halves are scanned together, so the block also reports the row of the lower half. The pixel rate comes from the system clock through a divider, which can be bypassed. Four inversion bits set the output polarity of vsync, hsync, the panel clock and data-enable.

The timing words and the dual-panel bit are taken into shadow copies while the block is disabled and at every frame boundary. A change written in the middle of a frame therefore never truncates a line or a frame.

Top module: `lcd_raster_gen`

## Requirements
- R1: A line lasts (timing_h[15:8]+1) + (timing_h[31:24]+1) + 16*(timing_h[7:2]+1) + (timing_h[23:16]+1) pixel clocks. Hsync is active during the first timing_h[15:8]+1 of them.
- R2: Within a line, data-enable first goes active (timing_h[15:8]+1)+(timing_h[31:24]+1) pixel clocks after hsync goes active. It then stays active for 16*(timing_h[7:2]+1) pixel clocks on an active row, and it never overlaps hsync or vsync.
- R3: A frame lasts (timing_v[15:10]+1) + timing_v[31:24] + (timing_v[9:0]+1) + timing_v[23:16] lines. Vsync is active for the first timing_v[15:10]+1 lines. The two porch fields are raw counts.
- R4: Data-enable is active only where both the column and the row are inside their active regions. During data-enable, pix_x runs from 0 to the active width minus 1 and pix_y runs from 0 to timing_v[9:0]. Both are 0 outside data-enable.
- R5: With ctrl_dual set, pix_y_lower equals pix_y + timing_v[9:0] + 1 during data-enable. With ctrl_dual clear, it equals pix_y.
- R6: When set, pol_inv[11] inverts vsync, pol_inv[12] inverts hsync, pol_inv[13] inverts panel_clk and pol_inv[14] inverts data_en. The change applies one system clock later.
- R7: With div_bypass clear, one pixel clock lasts clk_div+1 system clocks. panel_clk is high while the phase counter of the divider is at least (clk_div+1)/2, rounded down. With div_bypass set, a pixel lasts one system clock and panel_clk stays high.
- R8: While ctrl_en is clear, and after reset, hsync, vsync, data_en and panel_clk sit at their inactive level (the value of their inversion bit), and pix_x, pix_y and pix_y_lower are 0. Two system clocks after ctrl_en is set, hsync and vsync are both active, because the frame starts in its first sync line.
- R9: panel_pwr equals ctrl_en AND ctrl_pwr, one system clock later.
- R10: A change to timing_h or timing_v made during a frame does not affect the rest of that frame. It takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Timing generator enable |
| ctrl_pwr | input | 1 | Panel power request |
| ctrl_dual | input | 1 | Dual-panel mode |
| timing_h | input | 30 | Horizontal word, bits 31:2 |
| timing_v | input | 32 | Vertical word |
| pol_inv | input | 4 | Inversion bits 14:11 |
| div_bypass | input | 1 | Pixel clock divider bypass |
| clk_div | input | DIV_W | Divider value (pixel = clk_div+1 clocks) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| data_en | output | 1 | Data-enable |
| panel_clk | output | 1 | Panel clock |
| panel_pwr | output | 1 | Gated panel power |
| pix_x | output | HCNT_W | Active column |
| pix_y | output | VCNT_W | Active row (upper half in dual mode) |
| pix_y_lower | output | VCNT_W | Row of the lower half in dual mode |

## Verification
The assertions check these properties on every cycle:
- Each position counter stays inside the programmed period.
- Data-enable never overlaps either sync.
- The column is zero on the first cycle of each active run.
- Data-enable stays off after the block has been disabled.
- Divider ticks are spaced apart when the divider is above zero.

Only the bench scenarios can show the rest:
- Exact line and frame periods, and sync widths, under the different field encodings.
- The active pixel counts and the largest column and row reached.
- The lower-half row offset in dual-panel mode, and the polarity inversions.
- The divider and bypass rates, and the panel clock duty.
- That a mid-frame write waits for the next frame.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  // Bit positions inside the inversion field
  localparam int BIT_INV_V  = 11;
  localparam int BIT_INV_H  = 12;
  localparam int BIT_INV_PC = 13;
  localparam int BIT_INV_DE = 14;

  typedef struct packed {
    logic [15:0] sync_len;
    logic [15:0] bp_len;
    logic [15:0] act_len;
    logic [15:0] fp_len;
  } axis_len_t;

  // Horizontal word: minus-one fields, width in 16-pixel units
  function automatic axis_len_t decode_horz(input logic [31:2] w);
    axis_len_t r;
    r.sync_len = {8'd0, w[15:8]} + 16'd1;
    r.fp_len   = {8'd0, w[23:16]} + 16'd1;
    r.bp_len   = {8'd0, w[31:24]} + 16'd1;
    r.act_len  = ({10'd0, w[7:2]} + 16'd1) << 4;
    return r;
  endfunction

  // Vertical word: sync and lines minus one, porches raw
  function automatic axis_len_t decode_vert(input logic [31:0] w);
    axis_len_t r;
    r.sync_len = {10'd0, w[15:10]} + 16'd1;
    r.act_len  = {6'd0, w[9:0]} + 16'd1;
    r.fp_len   = {8'd0, w[23:16]};
    r.bp_len   = {8'd0, w[31:24]};
    return r;
  endfunction

endpackage

// File: rtl/lcdt_clkgen.sv
module lcdt_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             pclk_raw
);

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] phase_n;
  logic [DIV_W:0]   half;

  assign div_eff = bypass ? '0 : div;
  assign tick    = (phase >= div_eff);
  assign phase_n = tick ? '0 : phase + 1'b1;
  assign half    = ({1'b0, div_eff} + 1'b1) >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      pclk_raw <= 1'b0;
    end else begin
      phase    <= phase_n;
      pclk_raw <= ({1'b0, phase_n} >= half);
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && div_eff != '0) |=> (!tick || div_eff == '0)); // R7

endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] sync_len,
  input  logic [W-1:0] bp_len,
  input  logic [W-1:0] act_len,
  input  logic [W-1:0] fp_len,
  output logic         in_sync,
  output logic         in_act,
  output logic         last,
  output logic [W-1:0] idx
);

  logic [W-1:0] cnt;
  logic [W-1:0] s_end;
  logic [W-1:0] a_beg;
  logic [W-1:0] a_end;
  logic [W-1:0] total;
  logic [W-1:0] beg_sum;
  logic [W-1:0] end_sum;

  assign beg_sum = sync_len + bp_len;
  assign end_sum = beg_sum + act_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_end <= '0;
      a_beg <= '0;
      a_end <= '0;
      total <= '0;
      cnt   <= '0;
    end else begin
      if (load) begin
        s_end <= sync_len;
        a_beg <= beg_sum;
        a_end <= end_sum;
        total <= end_sum + fp_len;
      end
      if (!run)
        cnt <= '0;
      else if (step)
        cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  assign last    = (cnt == total - 1'b1);
  assign in_sync = (cnt < s_end);
  assign in_act  = (cnt >= a_beg) && (cnt < a_end);
  assign idx     = cnt - a_beg;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < total)); // R1 R3

endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcdt_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HCNT_W = 13,
  parameter int VCNT_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_en,
  input  logic              ctrl_pwr,
  input  logic              ctrl_dual,
  input  logic [31:2]       timing_h,
  input  logic [31:0]       timing_v,
  input  logic [14:11]      pol_inv,
  input  logic              div_bypass,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              hsync,
  output logic              vsync,
  output logic              data_en,
  output logic              panel_clk,
  output logic              panel_pwr,
  output logic [HCNT_W-1:0] pix_x,
  output logic [VCNT_W-1:0] pix_y,
  output logic [VCNT_W-1:0] pix_y_lower
);

  axis_len_t hl;
  axis_len_t vl;
  assign hl = decode_horz(timing_h);
  assign vl = decode_vert(timing_v);

  logic tick, pclk_raw;
  logic started_q;
  logic load;
  logic h_sync, h_act, h_last;
  logic v_sync, v_act, v_last;
  logic [HCNT_W-1:0] h_idx;
  logic [VCNT_W-1:0] v_idx;
  logic frame_wrap;

  // Shadow of the frame-level settings
  logic              dual_q;
  logic [VCNT_W-1:0] lines_q;

  // Registered logic levels and outputs
  logic              hs_l, vs_l, de_l, pc_l;
  logic [14:11]      inv_q;
  logic              pwr_q;
  logic [HCNT_W-1:0] pix_x_q;
  logic [VCNT_W-1:0] pix_y_q, pix_yl_q;

  lcdt_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .bypass   (div_bypass),
    .div      (clk_div),
    .tick     (tick),
    .pclk_raw (pclk_raw)
  );

  assign frame_wrap = started_q && tick && h_last && v_last;
  assign load       = !started_q || frame_wrap;

  lcdt_axis #(.W(HCNT_W)) u_h (
    .clk      (clk),
    .rst      (rst),
    .run      (started_q),
    .step     (tick),
    .load     (load),
    .sync_len (HCNT_W'(hl.sync_len)),
    .bp_len   (HCNT_W'(hl.bp_len)),
    .act_len  (HCNT_W'(hl.act_len)),
    .fp_len   (HCNT_W'(hl.fp_len)),
    .in_sync  (h_sync),
    .in_act   (h_act),
    .last     (h_last),
    .idx      (h_idx)
  );

  lcdt_axis #(.W(VCNT_W)) u_v (
    .clk      (clk),
    .rst      (rst),
    .run      (started_q),
    .step     (tick && h_last),
    .load     (load),
    .sync_len (VCNT_W'(vl.sync_len)),
    .bp_len   (VCNT_W'(vl.bp_len)),
    .act_len  (VCNT_W'(vl.act_len)),
    .fp_len   (VCNT_W'(vl.fp_len)),
    .in_sync  (v_sync),
    .in_act   (v_act),
    .last     (v_last),
    .idx      (v_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      inv_q     <= '0;
      pwr_q     <= 1'b0;
      dual_q    <= 1'b0;
      lines_q   <= '0;
    end else begin
      started_q <= ctrl_en;
      inv_q     <= pol_inv;
      pwr_q     <= ctrl_en && ctrl_pwr;
      if (load) begin
        dual_q  <= ctrl_dual;
        lines_q <= VCNT_W'(vl.act_len);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !started_q) begin
      hs_l     <= 1'b0;
      vs_l     <= 1'b0;
      de_l     <= 1'b0;
      pc_l     <= 1'b0;
      pix_x_q  <= '0;
      pix_y_q  <= '0;
      pix_yl_q <= '0;
    end else begin
      hs_l <= h_sync;
      vs_l <= v_sync;
      de_l <= h_act && v_act;
      pc_l <= pclk_raw;
      if (h_act && v_act) begin
        pix_x_q  <= h_idx;
        pix_y_q  <= v_idx;
        pix_yl_q <= dual_q ? v_idx + lines_q : v_idx;
      end else begin
        pix_x_q  <= '0;
        pix_y_q  <= '0;
        pix_yl_q <= '0;
      end
    end
  end

  assign hsync       = hs_l ^ inv_q[BIT_INV_H];
  assign vsync       = vs_l ^ inv_q[BIT_INV_V];
  assign data_en     = de_l ^ inv_q[BIT_INV_DE];
  assign panel_clk   = pc_l ^ inv_q[BIT_INV_PC];
  assign panel_pwr   = pwr_q;
  assign pix_x       = pix_x_q;
  assign pix_y       = pix_y_q;
  assign pix_y_lower = pix_yl_q;

  AST_IDLE_NO_DE: assert property (@(posedge clk) disable iff (rst)
    $past(!ctrl_en, 2) |-> !de_l); // R8

  AST_DE_SYNC_EXCL: assert property (@(posedge clk) disable iff (rst)
    de_l |-> (!hs_l && !vs_l)); // R2

  AST_FIRST_PIXEL: assert property (@(posedge clk) disable iff (rst)
    $rose(de_l) |-> (pix_x_q == '0)); // R4

endmodule

// File: tb/lcd_raster_gen_tb.sv
module lcd_raster_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W  = 8;
  localparam int HCNT_W = 13;
  localparam int VCNT_W = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_en = 1'b0, ctrl_pwr = 1'b0, ctrl_dual = 1'b0;
  logic [31:2] timing_h = '0;
  logic [31:0] timing_v = '0;
  logic [14:11] pol_inv = '0;
  logic div_bypass = 1'b0;
  logic [DIV_W-1:0] clk_div = '0;
  logic hsync, vsync, data_en, panel_clk, panel_pwr;
  logic [HCNT_W-1:0] pix_x;
  logic [VCNT_W-1:0] pix_y, pix_y_lower;

  int checks = 0;
  int fails = 0;
  bit ih = 0, iv = 0, ipc = 0, ide = 0;
  int exp_lines = 0;
  bit exp_dual = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_raster_gen #(.DIV_W(DIV_W), .HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_dut (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .ctrl_pwr(ctrl_pwr),
    .ctrl_dual(ctrl_dual), .timing_h(timing_h), .timing_v(timing_v),
    .pol_inv(pol_inv), .div_bypass(div_bypass), .clk_div(clk_div),
    .hsync(hsync), .vsync(vsync), .data_en(data_en), .panel_clk(panel_clk),
    .panel_pwr(panel_pwr), .pix_x(pix_x), .pix_y(pix_y),
    .pix_y_lower(pix_y_lower)
  );

  function automatic logic [31:2] mk_h(input int act16, input int hsw,
                                       input int hbp, input int hfp);
    return {8'(hbp - 1), 8'(hfp - 1), 8'(hsw - 1), 6'(act16 - 1)};
  endfunction

  function automatic logic [31:0] mk_v(input int lines, input int vsw,
                                       input int vbp, input int vfp);
    return {8'(vbp), 8'(vfp), 6'(vsw - 1), 10'(lines - 1)};
  endfunction

  function automatic bit lvl(input int w);
    case (w)
      0:       return hsync ^ ih;
      1:       return vsync ^ iv;
      default: return data_en ^ ide;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise(input int w);
    bit p;
    p = lvl(w);
    forever begin
      @(negedge clk);
      if (!p && lvl(w)) break;
      p = lvl(w);
    end
  endtask

  task automatic measure_line(input bit need_de, output int per, output int hi,
                              output int dec, output int lead, output int pch);
    bit p;
    if (need_de) wait_rise(2);
    wait_rise(0);
    per = 0; hi = 0; dec = 0; lead = -1; pch = 0; p = 1'b1;
    forever begin
      if (lvl(0)) hi++;
      if (lvl(2)) begin
        dec++;
        if (lead < 0) lead = per;
      end
      if (panel_clk ^ ipc) pch++;
      per++;
      @(negedge clk);
      if (!p && lvl(0)) break;
      p = lvl(0);
    end
  endtask

  task automatic measure_frame(output int per, output int vhi, output int dec,
                               output int maxx, output int maxy, output int lerr);
    bit p;
    int e;
    wait_rise(1);
    per = 0; vhi = 0; dec = 0; maxx = 0; maxy = 0; lerr = 0; p = 1'b1;
    forever begin
      if (lvl(1)) vhi++;
      if (lvl(2)) begin
        dec++;
        if (int'(pix_x) > maxx) maxx = int'(pix_x);
        if (int'(pix_y) > maxy) maxy = int'(pix_y);
        e = exp_dual ? int'(pix_y) + exp_lines : int'(pix_y);
        if (int'(pix_y_lower) != e) lerr++;
      end
      per++;
      @(negedge clk);
      if (!p && lvl(1)) break;
      p = lvl(1);
    end
  endtask

  task automatic restart(input logic [31:2] h, input logic [31:0] v, input int lines);
    ctrl_en = 1'b0;
    repeat (3) @(negedge clk);
    timing_h = h;
    timing_v = v;
    exp_lines = lines;
    exp_dual = ctrl_dual;
    ctrl_en = 1'b1;
  endtask

  task automatic t_reset();
    chk(hsync == 0 && vsync == 0 && data_en == 0 && panel_clk == 0, "R8 reset idle levels",
        {hsync, vsync, data_en, panel_clk}, 0);
    chk(pix_x == 0 && pix_y == 0 && pix_y_lower == 0 && panel_pwr == 0, "R8 reset pixel/power",
        int'(pix_x) + int'(pix_y) + int'(panel_pwr), 0);
  endtask

  task automatic t_enable();
    restart(mk_h(1, 2, 3, 1), mk_v(4, 1, 2, 1), 4);
    repeat (2) @(negedge clk);
    chk(hsync == 1 && vsync == 1, "R8 start in sync line", {hsync, vsync}, 3);
  endtask

  task automatic t_line_a();
    int per, hi, dec, lead, pch;
    restart(mk_h(1, 2, 3, 1), mk_v(4, 1, 2, 1), 4);
    measure_line(1'b1, per, hi, dec, lead, pch);
    chk(per == 22, "R1 line period A", per, 22);
    chk(hi == 2, "R1 hsync width A", hi, 2);
    chk(dec == 16, "R2 active pixels A", dec, 16);
    chk(lead == 5, "R2 sync+back porch lead A", lead, 5);
  endtask

  task automatic t_frame_a();
    int per, vhi, dec, mx, my, le;
    restart(mk_h(1, 2, 3, 1), mk_v(4, 1, 2, 1), 4);
    measure_frame(per, vhi, dec, mx, my, le);
    chk(per == 176, "R3 frame period A", per, 176);
    chk(vhi == 22, "R3 vsync width A", vhi, 22);
    chk(dec == 64, "R4 de count A", dec, 64);
    chk(mx == 15, "R4 max pix_x A", mx, 15);
    chk(my == 3, "R4 max pix_y A", my, 3);
    chk(le == 0, "R5 single mode lower row", le, 0);
  endtask

  task automatic t_cfg_b();
    int per, hi, dec, lead, pch, vhi, mx, my, le;
    restart(mk_h(2, 3, 1, 4), mk_v(6, 2, 0, 0), 6);
    measure_line(1'b1, per, hi, dec, lead, pch);
    chk(per == 40, "R1 line period B", per, 40);
    chk(hi == 3, "R1 hsync width B", hi, 3);
    chk(lead == 4, "R2 lead B", lead, 4);
    measure_frame(per, vhi, dec, mx, my, le);
    chk(per == 320, "R3 frame period B raw zero porches", per, 320);
    chk(vhi == 80, "R3 vsync width B", vhi, 80);
    chk(dec == 192, "R4 de count B", dec, 192);
    chk(mx == 31 && my == 5, "R4 max pix B", mx * 100 + my, 3105);
  endtask

  task automatic t_dual();
    int per, vhi, dec, mx, my, le;
    ctrl_dual = 1'b1;
    restart(mk_h(1, 2, 3, 1), mk_v(4, 1, 2, 1), 4);
    measure_frame(per, vhi, dec, mx, my, le);
    chk(le == 0, "R5 dual lower row offset", le, 0);
    chk(dec == 64 && per == 176, "R5 dual frame shape", dec, 64);
    ctrl_dual = 1'b0;
  endtask

  task automatic t_pol();
    int per, hi, dec, lead, pch;
    ctrl_en = 1'b0;
    pol_inv = 4'b1111;
    ih = 1; iv = 1; ipc = 1; ide = 1;
    repeat (4) @(negedge clk);
    chk(hsync == 1 && vsync == 1 && data_en == 1 && panel_clk == 1,
        "R6 R8 inverted idle levels", {hsync, vsync, data_en, panel_clk}, 15);
    restart(mk_h(1, 2, 3, 1), mk_v(4, 1, 2, 1), 4);
    measure_line(1'b1, per, hi, dec, lead, pch);
    chk(per == 22 && hi == 2, "R6 inverted hsync width", hi, 2);
    chk(dec == 16, "R6 inverted data_en count", dec, 16);
    chk(pch == 22, "R6 inverted panel clock", pch, 22);
    ctrl_en = 1'b0;
    pol_inv = 4'b0000;
    ih = 0; iv = 0; ipc = 0; ide = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_div();
    int per, hi, dec, lead, pch;
    clk_div = 8'd3;
    restart(mk_h(1, 2, 3, 1), mk_v(4, 1, 2, 1), 4);
    measure_line(1'b1, per, hi, dec, lead, pch);
    chk(per == 88, "R7 divided line period", per, 88);
    chk(pch == 44, "R7 divided panel clock duty", pch, 44);
    div_bypass = 1'b1;
    restart(mk_h(1, 2, 3, 1), mk_v(4, 1, 2, 1), 4);
    measure_line(1'b1, per, hi, dec, lead, pch);
    chk(per == 22, "R7 bypass line period", per, 22);
    chk(pch == 22, "R7 bypass panel clock high", pch, 22);
    div_bypass = 1'b0;
    clk_div = '0;
  endtask

  task automatic t_pwr();
    ctrl_en = 1'b1; ctrl_pwr = 1'b1;
    repeat (2) @(negedge clk);
    chk(panel_pwr == 1, "R9 power on", panel_pwr, 1);
    ctrl_pwr = 1'b0;
    repeat (2) @(negedge clk);
    chk(panel_pwr == 0, "R9 power request clear", panel_pwr, 0);
    ctrl_en = 1'b0; ctrl_pwr = 1'b1;
    repeat (2) @(negedge clk);
    chk(panel_pwr == 0, "R9 power gated by enable", panel_pwr, 0);
    ctrl_pwr = 1'b0;
  endtask

  task automatic t_shadow();
    int per, hi, dec, lead, pch, vhi, mx, my, le;
    restart(mk_h(1, 2, 3, 1), mk_v(4, 1, 2, 1), 4);
    wait_rise(2);
    timing_h = mk_h(2, 2, 3, 1);
    measure_line(1'b0, per, hi, dec, lead, pch);
    chk(per == 22, "R10 old line kept mid-frame", per, 22);
    measure_frame(per, vhi, dec, mx, my, le);
    chk(per == 304, "R10 new timing next frame", per, 304);
    chk(dec == 128, "R10 new width next frame", dec, 128);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_enable();
    t_line_a();
    t_frame_a();
    t_cfg_b();
    t_dual();
    t_pol();
    t_div();
    t_pwr();
    t_shadow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule